// File: doc/BRIEF.md
# Frame and multiframe sync generator

This block takes one output clock and produces two periodic sync signals from it. The frame sync repeats every 125 µs (8 kHz). The multiframe sync repeats every 500 µs (2 kHz) and always starts on a frame boundary. The integrator supplies a divide ratio N, equal to the clock frequency divided by 8000. A frame therefore spans N clock cycles and a multiframe spans 4N.

Each of the two outputs has three control bits of its own:
- an enable;
- a shape select, which picks either a 50% square wave or a one-clock-wide low pulse on a high baseline;
- a polarity flip, which inverts whichever shape is selected.

A disabled output is held low. Both outputs leave flops, so they are free of glitches.

Top module: `fsg_sync_gen`

## Requirements
- R1: With the frame shape select at 0, `fs_o` is high for the first floor(N/2) cycles of each N-cycle frame and low for the remaining cycles.
- R2: With the multiframe shape select at 0, `mfs_o` is high during frames 0 and 1 of each four-frame multiframe and low during frames 2 and 3. Each of its rising edges coincides with the start of a frame.
- R3: With the frame shape select at 1, `fs_o` is high except for exactly one clock cycle per frame, which is the first cycle of the frame (count 0).
- R4: With the multiframe shape select at 1, `mfs_o` is high except for one clock cycle every 4N cycles. That low cycle is the first cycle of frame 0, so it coincides with a frame-sync pulse.
- R5: A polarity bit of 1 inverts its output in both shapes. Pulse mode with inversion gives a one-clock high pulse on a low baseline.
- R6: A deasserted enable drives its output low, starting with the output value registered at the next rising edge.
- R7: The two outputs are controlled independently. Changing one output's control bits has no effect on the other output.
- R8: A new divide ratio is captured only when the frame counter wraps, so the frame in progress completes with the old ratio. The value on `div_i` is also captured while reset is asserted.
- R9: While synchronous reset is asserted, both outputs are low and both counters are cleared. After the first rising edge with reset low, the outputs show count 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output clock that both syncs are derived from |
| rst_i | input | 1 | Synchronous reset, active high |
| div_i | input | CNT_W | Divide ratio N (clock frequency / 8000). Must be at least 2, and at least 193 when pulse mode is used |
| fs_en_i | input | 1 | Frame sync enable |
| fs_pulse_i | input | 1 | Frame sync shape: 0 = square, 1 = one-clock pulse |
| fs_inv_i | input | 1 | Frame sync polarity flip |
| mfs_en_i | input | 1 | Multiframe sync enable |
| mfs_pulse_i | input | 1 | Multiframe sync shape: 0 = square, 1 = one-clock pulse |
| mfs_inv_i | input | 1 | Multiframe sync polarity flip |
| fs_o | output | 1 | 8 kHz frame sync |
| mfs_o | output | 1 | 2 kHz multiframe sync |

## Verification
The hardest case to reach from the ports is a divide-ratio change in the middle of a frame. The old ratio must keep governing the frame in progress, and the new ratio must apply from the very next boundary. To reach it, the bench changes `div_i` partway through a frame, in both directions (to a longer frame and to a shorter one). It predicts every output cycle with a step model that captures the new ratio only at a wrap. Pulse mode is run at the minimum legal ratio of 193 across two full multiframes, so that the single low cycle of the 2 kHz output must be seen to line up with a frame pulse.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef struct packed {
      logic en;
      logic pulse;
      logic inv;
   } fsg_ctl_t;

   localparam int unsigned FSG_LANES = 2;
endpackage

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned FRAMES = 4,
   localparam int unsigned FR_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] div_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] div_o,
   output logic [FR_W-1:0]  fidx_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q, div_q;
   logic [FR_W-1:0]  fidx_q;
   logic             wrap;

   assign wrap = (cnt_q == div_q - 1'b1);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         fidx_q <= '0;
         div_q  <= div_i;
      end else if (wrap) begin
         cnt_q  <= '0;
         div_q  <= div_i;
         fidx_q <= (fidx_q == FR_W'(FRAMES - 1)) ? '0 : fidx_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign div_o  = div_q;
   assign fidx_o = fidx_q;
   assign wrap_o = wrap;

   p_wrap_to_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap |=> (cnt_q == '0));
   p_div_held_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap |=> $stable(div_q));
   p_fidx_held_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap |=> $stable(fidx_q));
   p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (div_q > 1) |-> (cnt_q < div_q));
endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper
   import fsg_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_i,
   input  fsg_ctl_t ctl_i,
   input  logic     level_i,
   input  logic     mark_i,
   output logic     out_o
);
   logic base, out_q;

   always_comb begin
      base = ctl_i.pulse ? ~mark_i : level_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) out_q <= 1'b0;
      else       out_q <= ctl_i.en & (base ^ ctl_i.inv);
   end

   assign out_o = out_q;

   p_disabled_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !ctl_i.en |=> !out_q);
   p_pulse_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (ctl_i.en && ctl_i.pulse && !ctl_i.inv && mark_i) |=> !out_q);
   p_pulse_high_inv_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (ctl_i.en && ctl_i.pulse && ctl_i.inv && mark_i) |=> out_q);
   p_reset_low_r9: assert property (@(posedge clk_i)
      rst_i |=> !out_q);
endmodule

// File: rtl/fsg_sync_gen.sv
module fsg_sync_gen
   import fsg_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned FRAMES = 4,
   localparam int unsigned FR_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] div_i,
   input  logic             fs_en_i,
   input  logic             fs_pulse_i,
   input  logic             fs_inv_i,
   input  logic             mfs_en_i,
   input  logic             mfs_pulse_i,
   input  logic             mfs_inv_i,
   output logic             fs_o,
   output logic             mfs_o
);
   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("CNT_W must hold a divide ratio of at least 193");
      end
      if (FRAMES < 2 || (FRAMES % 2) != 0) begin : g_bad_frames
         $error("FRAMES must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, div_q, half;
   logic [FR_W-1:0]  fidx;
   logic             wrap;

   fsg_frame_ctr #(.CNT_W(CNT_W), .FRAMES(FRAMES)) u_ctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .div_i  (div_i),
      .cnt_o  (cnt),
      .div_o  (div_q),
      .fidx_o (fidx),
      .wrap_o (wrap)
   );

   assign half = div_q >> 1;

   fsg_ctl_t                ctl  [FSG_LANES];
   logic [FSG_LANES-1:0]    lvl, mark, outs;

   assign ctl[0] = '{en: fs_en_i,  pulse: fs_pulse_i,  inv: fs_inv_i};
   assign ctl[1] = '{en: mfs_en_i, pulse: mfs_pulse_i, inv: mfs_inv_i};

   generate
      for (genvar g = 0; g < FSG_LANES; g++) begin : g_lane
         if (g == 0) begin : g_frame
            assign lvl[g]  = (cnt < half);
            assign mark[g] = (cnt == '0);
         end else begin : g_multi
            assign lvl[g]  = (fidx < FR_W'(FRAMES / 2));
            assign mark[g] = (cnt == '0) && (fidx == '0);
         end
         fsg_shaper u_shape (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .ctl_i   (ctl[g]),
            .level_i (lvl[g]),
            .mark_i  (mark[g]),
            .out_o   (outs[g])
         );
      end
   endgenerate

   assign fs_o  = outs[0];
   assign mfs_o = outs[1];

   p_mf_mark_on_frame_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      mark[1] |-> mark[0]);
   p_mf_rise_on_frame_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (mfs_en_i && !mfs_pulse_i && !mfs_inv_i && $past(mfs_en_i && !mfs_pulse_i && !mfs_inv_i)
       && $rose(mfs_o)) |-> (cnt == 1 || div_q == 1));
endmodule

// File: tb/fsg_sync_gen_tb_top.sv
module fsg_sync_gen_tb_top;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] div = 16'd10;
   logic fs_en = 1'b0, fs_pul = 1'b0, fs_inv = 1'b0;
   logic mf_en = 1'b0, mf_pul = 1'b0, mf_inv = 1'b0;
   logic fs_o, mfs_o;

   int n_chk = 0, n_bad = 0;
   int m_c = 0, m_f = 0, m_n = 10;

   always #5ns clk = ~clk;

   fsg_sync_gen #(.CNT_W(CW), .FRAMES(4)) dut_i (
      .clk_i(clk), .rst_i(rst), .div_i(div),
      .fs_en_i(fs_en), .fs_pulse_i(fs_pul), .fs_inv_i(fs_inv),
      .mfs_en_i(mf_en), .mfs_pulse_i(mf_pul), .mfs_inv_i(mf_inv),
      .fs_o(fs_o), .mfs_o(mfs_o)
   );

   function automatic logic expv(int ch, int c, int f, int n, logic en, logic pul, logic inv);
      logic b;
      if (pul) b = !(c == 0 && (ch == 0 || f == 0));
      else     b = (ch == 0) ? (c < n / 2) : (f < 2);
      return en & (b ^ inv);
   endfunction

   task automatic chk(string tag, int ch, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s ch%0d c=%0d f=%0d actual=%b expected=%b", tag, ch, m_c, m_f, act, exp);
      end
   endtask

   task automatic do_reset(int n);
      rst = 1'b1;
      div = CW'(n);
      @(negedge clk);
      @(negedge clk);
      chk("R9 reset", 0, fs_o, 1'b0);
      chk("R9 reset", 1, mfs_o, 1'b0);
      m_c = 0; m_f = 0; m_n = n;
      rst = 1'b0;
   endtask

   task automatic run(string tag, int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         chk(tag, 0, fs_o,  expv(0, m_c, m_f, m_n, fs_en, fs_pul, fs_inv));
         chk(tag, 1, mfs_o, expv(1, m_c, m_f, m_n, mf_en, mf_pul, mf_inv));
         if (m_c == m_n - 1) begin
            m_c = 0; m_f = (m_f + 1) % 4; m_n = int'(div);
         end else begin
            m_c++;
         end
      end
   endtask

   task automatic t_square;
      fs_en = 1; fs_pul = 0; fs_inv = 0; mf_en = 1; mf_pul = 0; mf_inv = 0;
      do_reset(10);
      run("R1 R2 R9 square even", 80);
      do_reset(9);
      run("R1 R2 square odd", 72);
   endtask

   task automatic t_pulse;
      fs_en = 1; fs_pul = 1; fs_inv = 0; mf_en = 1; mf_pul = 1; mf_inv = 0;
      do_reset(193);
      run("R3 R4 pulse", 193 * 8);
   endtask

   task automatic t_invert;
      fs_en = 1; fs_pul = 0; fs_inv = 1; mf_en = 1; mf_pul = 0; mf_inv = 1;
      do_reset(12);
      run("R5 square inverted", 96);
      fs_pul = 1; mf_pul = 1;
      do_reset(193);
      run("R5 pulse inverted", 193 * 4 + 5);
   endtask

   task automatic t_mixed;
      fs_en = 1; fs_pul = 1; fs_inv = 0; mf_en = 1; mf_pul = 0; mf_inv = 1;
      do_reset(200);
      run("R7 mixed", 300);
      mf_pul = 1; mf_inv = 0;
      run("R7 other lane changed", 900);
   endtask

   task automatic t_disable;
      fs_en = 1; fs_pul = 0; fs_inv = 1; mf_en = 1; mf_pul = 0; mf_inv = 1;
      do_reset(10);
      run("R6 enabled", 13);
      fs_en = 0;
      run("R6 frame disabled", 30);
      mf_en = 0;
      run("R6 both disabled", 30);
      fs_en = 1;
      run("R6 reenabled", 20);
   endtask

   task automatic t_div_change;
      fs_en = 1; fs_pul = 0; fs_inv = 0; mf_en = 1; mf_pul = 0; mf_inv = 0;
      do_reset(10);
      run("R8 before", 15);
      div = 16'd14;
      run("R8 longer", 120);
      div = 16'd8;
      run("R8 shorter", 5);
      div = 16'd6;
      run("R8 mid change", 80);
   endtask

   initial begin
      #2ms;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_square();
      t_pulse();
      t_invert();
      t_mixed();
      t_disable();
      t_div_change();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule